// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a direct-mapped cache and in front of the next memory level. Whenever the cache controller reports a miss, the block compares the missing block address with the tag of the oldest prefetched block it holds. On a match, that block is handed back in the same cycle and leaves the buffer. This frees a slot, which is then refilled with the next block in sequence. On a mismatch, every stored block is dropped and prefetching starts again at the block that follows the missing one. The cache fetches the missing block itself.

The prefetched blocks live in a small circular queue. Each slot holds a valid flag, the block address and the block data. Only one request to the next level is in flight at any time. A request is only issued when the slot it will fill is free. Each request carries a short generation tag. When the buffer is restarted, the generation changes, so a response that belongs to an abandoned stream is recognised and thrown away.

Top module: `seq_stream_prefetch`

## Requirements
- R1: After reset no slot is valid, `lk_hit` stays low and no next-level request is issued until the first lookup arrives.
- R2: A lookup hits, in the same cycle as `lk_valid`, exactly when the oldest slot is valid and its stored block address equals `lk_addr`; `lk_data` then carries that block's data.
- R3: A hit removes the oldest slot, so the following block becomes the one compared, and back-to-back lookups of consecutive addresses hit as long as blocks are stored.
- R4: A lookup that does not hit discards all stored blocks, issues no request in that cycle, and the first request after it asks for `lk_addr + 1`.
- R5: Each further request asks for the previous request address plus one, wrapping at the top of the address range.
- R6: At most one request is outstanding; a new request waits until the response to the previous one has arrived.
- R7: No request is issued while all DEPTH slots are valid or reserved, so after a restart and an idle period exactly DEPTH blocks are requested.
- R8: A response whose `mem_rsp_tag` differs from the tag of the current stream is not stored; the stream that replaced it still fills with its own blocks.
- R9: Only the oldest slot is compared: a lookup of a block stored behind the oldest one is a miss and restarts the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Cache miss lookup strobe |
| lk_addr | input | ADDR_W | Block address that missed in the cache |
| lk_hit | output | 1 | Oldest stored block matches the lookup |
| lk_data | output | DATA_W | Data of the matching block |
| mem_req | output | 1 | Request strobe to the next level |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_tag | output | GEN_W | Stream generation tag of the request |
| mem_rsp_valid | input | 1 | Response strobe from the next level |
| mem_rsp_tag | input | GEN_W | Generation tag echoed with the response |
| mem_rsp_data | input | DATA_W | Returned block data |

## Verification
The bench builds the block with DEPTH 4, ADDR_W 16, DATA_W 32 and GEN_W 2. The shallow queue lets an idle gap of a few dozen cycles fill it completely, which makes the full-queue stall and the back-to-back pop of every slot easy to observe. The 16-bit address makes wrap-around from the top block reachable. The memory model's latency can be varied from one to five cycles. This lets a restart land while a request is still in flight, so the stale-tag discard is exercised against data that would visibly corrupt the next stream if it were stored.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Stream state of the fetch engine
    typedef enum logic [0:0] {
        SB_COLD      = 1'b0,
        SB_STREAMING = 1'b1
    } sb_mode_e;

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_flush,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              fifo_full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [DEPTH-1:0][ADDR_W-1:0] tag;
        logic [DEPTH-1:0][DATA_W-1:0] data;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic head_vld;

    always_comb begin
        head_vld  = st_q.vld[st_q.head];
        lk_hit    = lk_valid && head_vld && (st_q.tag[st_q.head] == lk_addr);
        lk_flush  = lk_valid && !lk_hit;
        lk_data   = st_q.data[st_q.head];
        fifo_full = st_q.vld[st_q.tail];

        st_d = st_q;
        if (lk_flush) begin
            st_d.vld  = '0;
            st_d.head = '0;
            st_d.tail = '0;
        end else begin
            if (lk_hit) begin
                st_d.vld[st_q.head] = 1'b0;
                st_d.head           = ptr_inc(st_q.head);
            end
            if (push_valid) begin
                st_d.vld[st_q.tail]  = 1'b1;
                st_d.tag[st_q.tail]  = push_addr;
                st_d.data[st_q.tail] = push_data;
                st_d.tail            = ptr_inc(st_q.tail);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld  <= '0;
            st_q.head <= '0;
            st_q.tail <= '0;
            st_q.tag  <= '0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A block is never written over a slot that still holds one
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !st_q.vld[st_q.tail]);

    // A hit with nothing arriving leaves one stored block fewer
    assert_pop_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !push_valid) |=>
            ($countones(st_q.vld) + 1 == $countones($past(st_q.vld))));

endmodule

// File: rtl/sb_fetch.sv
module sb_fetch
    import sb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_flush,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fifo_full,
    input  logic              rsp_valid,
    input  logic [GEN_W-1:0]  rsp_tag,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [GEN_W-1:0]  mem_req_tag,
    output logic              push_valid,
    output logic [ADDR_W-1:0] push_addr
);

    typedef struct packed {
        sb_mode_e          mode;
        logic              outst;
        logic [ADDR_W-1:0] next_addr;
        logic [ADDR_W-1:0] pend_addr;
        logic [GEN_W-1:0]  gen;
    } fetch_st_t;

    fetch_st_t st_d, st_q;

    always_comb begin
        mem_req      = (st_q.mode == SB_STREAMING) && !st_q.outst && !fifo_full && !lk_flush;
        mem_req_addr = st_q.next_addr;
        mem_req_tag  = st_q.gen;
        push_valid   = rsp_valid && st_q.outst && (rsp_tag == st_q.gen) && !lk_flush;
        push_addr    = st_q.pend_addr;

        st_d = st_q;
        if (rsp_valid) begin
            st_d.outst = 1'b0;
        end
        if (mem_req) begin
            st_d.outst     = 1'b1;
            st_d.pend_addr = st_q.next_addr;
            st_d.next_addr = st_q.next_addr + ADDR_W'(1);
        end
        if (lk_flush) begin
            st_d.mode      = SB_STREAMING;
            st_d.gen       = st_q.gen + GEN_W'(1);
            st_d.next_addr = lk_addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= SB_COLD;
            st_q.outst     <= 1'b0;
            st_q.next_addr <= '0;
            st_q.pend_addr <= '0;
            st_q.gen       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A stored response always matches the block that was asked for last
    assert_push_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (push_addr + ADDR_W'(1) == st_q.next_addr));

endmodule

// File: rtl/seq_stream_prefetch.sv
module seq_stream_prefetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int GEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [GEN_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [GEN_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic              lk_flush;
    logic              fifo_full;
    logic              push_valid;
    logic [ADDR_W-1:0] push_addr;

    sb_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .lk_flush   (lk_flush),
        .push_valid (push_valid),
        .push_addr  (push_addr),
        .push_data  (mem_rsp_data),
        .fifo_full  (fifo_full)
    );

    sb_fetch #(
        .ADDR_W (ADDR_W),
        .GEN_W  (GEN_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_flush     (lk_flush),
        .lk_addr      (lk_addr),
        .fifo_full    (fifo_full),
        .rsp_valid    (mem_rsp_valid),
        .rsp_tag      (mem_rsp_tag),
        .mem_req      (mem_req),
        .mem_req_addr (mem_req_addr),
        .mem_req_tag  (mem_req_tag),
        .push_valid   (push_valid),
        .push_addr    (push_addr)
    );

    // Request after a restart targets the block following the miss
    assert_restart_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |=> (mem_req |-> (mem_req_addr == $past(lk_addr) + ADDR_W'(1))));

    // Requests are separated by at least one response cycle
    assert_no_back_to_back_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

// File: tb/seq_stream_prefetch_bench.sv
`timescale 1ns/100ps
module seq_stream_prefetch_bench;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DP = 4;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;
    logic          mem_req;
    logic [AW-1:0] mem_req_addr;
    logic [GW-1:0] mem_req_tag;
    logic          mem_rsp_valid = 1'b0;
    logic [GW-1:0] mem_rsp_tag = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    seq_stream_prefetch #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .GEN_W(GW)) u_seq_stream_prefetch (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_data(lk_data), .mem_req(mem_req),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard of expected lookup results
    typedef struct { bit hit; logic [AW-1:0] addr; } exp_t;
    exp_t sb_q[$];

    // Bench model of the buffer, from the requirements
    bit            started   = 1'b0;
    logic [AW-1:0] m_head    = '0;
    int            m_count   = 0;
    logic [AW-1:0] exp_next  = '0;
    int            req_cnt   = 0;
    int            mem_lat   = 2;

    task automatic lookup(input logic [AW-1:0] a);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        e.addr   = a;
        e.hit    = (m_count > 0) && (a == m_head);
        sb_q.push_back(e);
        started = 1'b1;
        if (e.hit) begin
            m_head  = a + 16'd1;
            m_count = m_count - 1;
        end else begin
            m_head   = a + 16'd1;
            m_count  = 0;
            exp_next = a + 16'd1;
            req_cnt  = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lk_valid = 1'b0;
        end
    endtask

    // Long idle: the queue is full again
    task automatic settle(input int n);
        idle(n);
        if (started) m_count = DP;
    endtask

    // Monitor: pops expectations and compares with the lookup result
    always begin
        @(negedge clk);
        #0.5;
        if (rst_n && lk_valid) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 scoreboard underflow", 0, 1);
            end else begin
                e = sb_q.pop_front();
                chk(lk_hit == e.hit, e.hit ? "R2/R3 hit" : "R4/R9 miss", lk_hit, e.hit);
                if (e.hit)
                    chk(lk_data == pat(e.addr), "R2 data", lk_data, pat(e.addr));
            end
        end
    end

    // Next-level memory model and request checks
    bit            mb_outst = 1'b0;
    bit            mp_pend  = 1'b0;
    int            mp_cnt   = 0;
    logic [AW-1:0] mp_addr  = '0;
    logic [GW-1:0] mp_tag   = '0;

    always begin
        @(negedge clk);
        #1;
        mem_rsp_valid = 1'b0;
        if (rst_n) begin
            if (mem_req) begin
                if (!started) chk(1'b0, "R1 request before first lookup", 1, 0);
                if (mb_outst) chk(1'b0, "R6 second outstanding request", 1, 0);
                if (lk_valid && !lk_hit) chk(1'b0, "R4 request during restart", 1, 0);
                chk(mem_req_addr == exp_next, "R4/R5 request address", mem_req_addr, exp_next);
                exp_next = exp_next + 16'd1;
                req_cnt++;
            end
            if (mp_pend) begin
                if (mp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pat(mp_addr);
                    mem_rsp_tag   = mp_tag;
                    mp_pend       = 1'b0;
                    mb_outst      = 1'b0;
                end else begin
                    mp_cnt--;
                end
            end
            if (mem_req) begin
                mb_outst = 1'b1;
                mp_pend  = 1'b1;
                mp_cnt   = mem_lat - 1;
                mp_addr  = mem_req_addr;
                mp_tag   = mem_req_tag;
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] r;
        idle(4);
        rst_n = 1'b1;
        idle(10);
        chk(lk_hit == 1'b0, "R1 hit low after reset", lk_hit, 0);
        chk(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);

        // Cold lookup, fill, then sequential hits back to back
        mem_lat = 2;
        lookup(16'h0100);
        settle(40);
        chk(req_cnt == DP, "R7 requests stop at depth", req_cnt, DP);
        for (int i = 1; i <= DP; i++) lookup(16'h0100 + 16'(i));
        settle(40);
        lookup(16'h0105);
        lookup(16'h0106);
        settle(40);

        // Only the oldest block is compared
        lookup(16'h0108);
        settle(40);

        // Lookup right after a restart finds nothing yet
        lookup(16'h0200);
        lookup(16'h0201);
        settle(40);
        lookup(16'h0202);
        settle(40);

        // Restart while a request is in flight: stale data must vanish
        mem_lat = 5;
        lookup(16'h0300);
        idle(2);
        lookup(16'h0700);
        settle(60);
        chk(req_cnt == DP, "R8 new stream fully requested", req_cnt, DP);
        for (int i = 1; i <= DP; i++) lookup(16'h0700 + 16'(i));
        settle(60);

        // Wrap at the top of the address range
        mem_lat = 1;
        lookup(16'hFFFE);
        settle(40);
        lookup(16'hFFFF);
        lookup(16'h0000);
        settle(40);
        lookup(16'h0001);
        settle(40);

        // Random miss stream mixed with sequential runs
        for (int k = 0; k < 12; k++) begin
            mem_lat = 1 + int'($urandom % 4);
            r = 16'($urandom);
            lookup(r);
            settle(60);
            lookup(r + 16'd1);
            lookup(r + 16'd2);
            settle(60);
            lookup(r + 16'd3);
            settle(60);
        end

        idle(5);
        chk(sb_q.size() == 0, "R2 all lookups observed", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule